// File: doc/BRIEF.md
# Banked Edge-Triggered Interrupt Line Controller

This block watches a set of asynchronous external signal lines, grouped into banks of 32, and turns selected signal edges into latched pending flags and per-bank level interrupts. For each line, software picks detection on the rising edge, the falling edge, or both. A detected edge is latched in one of two separate pending registers: one for rising edges and one for falling edges. Software clears a flag by writing a 1 to its bit.

Each bank drives one active-high level interrupt. That output is the OR, over all of the bank's lines, of the pending flags gated by an interrupt-enable mask. A second mask, the event-enable mask, turns each detected edge into a one-clock pulse on a per-line event output. Software can also raise a line's rising-edge flag by writing to a trigger register. A bank may implement fewer than 32 lines. Unimplemented bits read back as zero, so software can find them by writing all ones and reading the value back.

Access goes through a plain valid/write/address/data register port. Read data depends only on the address and is available in the same cycle.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, every register of every bank reads 0, and all irq_out and event_out bits are 0.
- R2: When only the rising-select bit of a line is set, a 0-to-1 change on that line sets the line's bit in the rising-pending register. The bank is line/32 and the bit is line%32. A 1-to-0 change sets nothing.
- R3: When only the falling-select bit is set, a 1-to-0 change sets the line's falling-pending bit and a 0-to-1 change sets nothing.
- R4: When both select bits are set, a rising change sets the rising-pending bit and a falling change sets the falling-pending bit.
- R5: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged.
- R6: If a detected edge and a write-1 clear reach the same pending bit in the same cycle, the bit stays set.
- R7: Writing 1 to a bit of the trigger register sets that line's rising-pending bit. The trigger register always reads 0.
- R8: irq_out[b] is 1 exactly while bank b has some bit set in (rising-pending OR falling-pending) AND interrupt-enable. It stays high until software clears the flag or the enable bit.
- R9: A detected edge on a line whose event-enable bit is 1 gives exactly one cycle of 1 on event_out[line]. An edge on a line whose event-enable bit is 0 gives no pulse.
- R10: For a line outside IMPL_MASK, the select, mask and pending bits are not writable and read 0, and that line never becomes pending.
- R11: Register map for bank b (byte addresses): rising-select 0x00+b*0x20, falling-select 0x04+b*0x20, trigger 0x08+b*0x20, rising-pending 0x0C+b*0x20, falling-pending 0x10+b*0x20, interrupt-enable 0x80+b*0x10, event-enable 0x84+b*0x10. A write to one bank's register changes no other register.
- R12: An input change is captured by a two-flop synchronizer. A pending bit is therefore set at the third rising clock edge after the input change and is not set after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lines_in | input | NUM_BANKS*32 | External lines, asynchronous to clk |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 for a write when reg_valid is high |
| reg_addr | input | 8 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, same cycle |
| irq_out | output | NUM_BANKS | Per-bank active-high level interrupt |
| event_out | output | NUM_BANKS*32 | Per-line one-cycle event pulse |

## Verification
Several properties are checked on every cycle:
- pending flags and the interrupt level fall only after a register write;
- a pending flag rises only after a write or after an input change three cycles earlier;
- event pulses come only from such input changes;
- unimplemented lines never hold a pending flag.

The bench scenarios cover the remaining behaviour:
- the edge polarity selected by each select combination;
- the exact three-cycle capture latency;
- the clear-versus-edge collision in a single cycle;
- the software trigger;
- the address map.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

    localparam int unsigned LINES_PER_BANK = 32;
    localparam int unsigned ADDR_W         = 8;

    typedef logic [LINES_PER_BANK-1:0] word_t;

    localparam logic [ADDR_W-1:0] TRIG_STRIDE = 8'h20;
    localparam logic [ADDR_W-1:0] MASK_BASE   = 8'h80;
    localparam logic [ADDR_W-1:0] MASK_STRIDE = 8'h10;

    localparam logic [ADDR_W-1:0] OFS_RSEL  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_FSEL  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_SWTRG = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_RPND  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_FPND  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_IEN   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_EEN   = 8'h04;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_RSEL,
        SEL_FSEL,
        SEL_SWTRG,
        SEL_RPND,
        SEL_FPND,
        SEL_IEN,
        SEL_EEN
    } reg_sel_e;

    typedef struct packed {
        word_t rsel;
        word_t fsel;
        word_t ien;
        word_t een;
        word_t rpnd;
        word_t fpnd;
        word_t evt;
    } bank_state_t;

    function automatic reg_sel_e decode_reg(input logic [ADDR_W-1:0] a,
                                            input int unsigned       bank);
        logic [ADDR_W-1:0] tbase;
        logic [ADDR_W-1:0] mbase;
        reg_sel_e          sel;
        tbase = ADDR_W'(bank) * TRIG_STRIDE;
        mbase = MASK_BASE + ADDR_W'(bank) * MASK_STRIDE;
        sel   = SEL_NONE;
        if (a == tbase + OFS_RSEL)       sel = SEL_RSEL;
        else if (a == tbase + OFS_FSEL)  sel = SEL_FSEL;
        else if (a == tbase + OFS_SWTRG) sel = SEL_SWTRG;
        else if (a == tbase + OFS_RPND)  sel = SEL_RPND;
        else if (a == tbase + OFS_FPND)  sel = SEL_FPND;
        else if (a == mbase + OFS_IEN)   sel = SEL_IEN;
        else if (a == mbase + OFS_EEN)   sel = SEL_EEN;
        return sel;
    endfunction

endpackage

// File: rtl/edge_irq_sync.sv
module edge_irq_sync #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] lvl_now,
    output logic [WIDTH-1:0] lvl_prev
);

    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
        logic [WIDTH-1:0] prev;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = async_in;
        st_d.stable = st_q.meta;
        st_d.prev   = st_q.stable;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_now  = st_q.stable;
    assign lvl_prev = st_q.prev;

endmodule

// File: rtl/edge_irq_bank.sv
module edge_irq_bank
    import edge_irq_pkg::*;
#(
    parameter int unsigned BANK_IDX = 0,
    parameter word_t       IMPL     = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  word_t             lvl_now,
    input  word_t             lvl_prev,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  word_t             wdata,
    output word_t             rdata,
    output word_t             rise_pend,
    output word_t             fall_pend,
    output logic              irq,
    output word_t             evt
);

    bank_state_t st_d, st_q;
    reg_sel_e    sel;
    word_t       rise_det, fall_det, clr_r, clr_f, sw_set, wmask;

    always_comb begin
        sel      = decode_reg(addr, BANK_IDX);
        wmask    = wdata & IMPL;
        rise_det = lvl_now & ~lvl_prev & st_q.rsel;
        fall_det = ~lvl_now & lvl_prev & st_q.fsel;
        clr_r    = (wr_en && sel == SEL_RPND)  ? wdata : '0;
        clr_f    = (wr_en && sel == SEL_FPND)  ? wdata : '0;
        sw_set   = (wr_en && sel == SEL_SWTRG) ? wmask : '0;

        st_d = st_q;
        if (wr_en) begin
            case (sel)
                SEL_RSEL: st_d.rsel = wmask;
                SEL_FSEL: st_d.fsel = wmask;
                SEL_IEN:  st_d.ien  = wmask;
                SEL_EEN:  st_d.een  = wmask;
                default:  ;
            endcase
        end
        // a fresh edge outranks a simultaneous clear
        st_d.rpnd = ((st_q.rpnd & ~clr_r) | rise_det | sw_set) & IMPL;
        st_d.fpnd = ((st_q.fpnd & ~clr_f) | fall_det) & IMPL;
        st_d.evt  = (rise_det | fall_det) & st_q.een;

        case (sel)
            SEL_RSEL: rdata = st_q.rsel;
            SEL_FSEL: rdata = st_q.fsel;
            SEL_RPND: rdata = st_q.rpnd;
            SEL_FPND: rdata = st_q.fpnd;
            SEL_IEN:  rdata = st_q.ien;
            SEL_EEN:  rdata = st_q.een;
            default:  rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_pend = st_q.rpnd;
    assign fall_pend = st_q.fpnd;
    assign evt       = st_q.evt;
    assign irq       = |((st_q.rpnd | st_q.fpnd) & st_q.ien);

endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
    import edge_irq_pkg::*;
#(
    parameter int unsigned                        NUM_BANKS = 3,
    parameter logic [NUM_BANKS*LINES_PER_BANK-1:0] IMPL_MASK =
        {32'h0001_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF}
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_BANKS*LINES_PER_BANK-1:0] lines_in,
    input  logic                                reg_valid,
    input  logic                                reg_write,
    input  logic [ADDR_W-1:0]                   reg_addr,
    input  logic [LINES_PER_BANK-1:0]           reg_wdata,
    output logic [LINES_PER_BANK-1:0]           reg_rdata,
    output logic [NUM_BANKS-1:0]                irq_out,
    output logic [NUM_BANKS*LINES_PER_BANK-1:0] event_out
);

    localparam int unsigned TOTAL = NUM_BANKS * LINES_PER_BANK;

    logic [TOTAL-1:0] lvl_now, lvl_prev;
    logic [TOTAL-1:0] rise_pend_all, fall_pend_all;
    word_t            bank_rd [NUM_BANKS];
    logic             wr_en;

    assign wr_en = reg_valid & reg_write;

    edge_irq_sync #(.WIDTH(TOTAL)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (lines_in),
        .lvl_now  (lvl_now),
        .lvl_prev (lvl_prev)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        edge_irq_bank #(
            .BANK_IDX (b),
            .IMPL     (IMPL_MASK[b*LINES_PER_BANK +: LINES_PER_BANK])
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .lvl_now   (lvl_now[b*LINES_PER_BANK +: LINES_PER_BANK]),
            .lvl_prev  (lvl_prev[b*LINES_PER_BANK +: LINES_PER_BANK]),
            .wr_en     (wr_en),
            .addr      (reg_addr),
            .wdata     (reg_wdata),
            .rdata     (bank_rd[b]),
            .rise_pend (rise_pend_all[b*LINES_PER_BANK +: LINES_PER_BANK]),
            .fall_pend (fall_pend_all[b*LINES_PER_BANK +: LINES_PER_BANK]),
            .irq       (irq_out[b]),
            .evt       (event_out[b*LINES_PER_BANK +: LINES_PER_BANK])
        );
    end

    // only the addressed bank returns non-zero data
    always_comb begin
        reg_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) reg_rdata |= bank_rd[b];
    end

endmodule

// File: rtl/edge_irq_ctrl_chk.sv
module edge_irq_ctrl_chk #(
    parameter int unsigned               NUM_BANKS = 3,
    parameter logic [NUM_BANKS*32-1:0]   IMPL_MASK = '1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NUM_BANKS*32-1:0] lines_in,
    input logic                    reg_valid,
    input logic                    reg_write,
    input logic [NUM_BANKS-1:0]    irq_out,
    input logic [NUM_BANKS*32-1:0] event_out,
    input logic [NUM_BANKS*32-1:0] rise_pend,
    input logic [NUM_BANKS*32-1:0] fall_pend
);

    logic [2:0] age_q;
    logic       ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            age_q <= '0;
        else if (age_q != 3'd7) age_q <= age_q + 3'd1;
    end
    assign ready = (age_q >= 3'd5);

    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (irq_out == '0 && event_out == '0)
                else $error("outputs active in reset");
        end
    end

    p_unimpl_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise_pend | fall_pend) & ~IMPL_MASK) == '0);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_b
        p_irq_drop_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (ready && $fell(irq_out[b])) |-> $past(reg_valid && reg_write));
    end

    for (genvar i = 0; i < NUM_BANKS*32; i++) begin : g_l
        p_rpend_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (ready && $fell(rise_pend[i])) |-> $past(reg_valid && reg_write));
        p_fpend_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (ready && $fell(fall_pend[i])) |-> $past(reg_valid && reg_write));
        p_rpend_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
            (ready && $rose(rise_pend[i])) |->
                ($past(reg_valid && reg_write) ||
                 ($past(lines_in[i], 3) != $past(lines_in[i], 4))));
        p_fpend_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (ready && $rose(fall_pend[i])) |->
                ($past(lines_in[i], 3) != $past(lines_in[i], 4)));
        p_event_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (ready && event_out[i]) |->
                ($past(lines_in[i], 3) != $past(lines_in[i], 4)));
    end

endmodule

bind edge_irq_ctrl edge_irq_ctrl_chk #(
    .NUM_BANKS (NUM_BANKS),
    .IMPL_MASK (IMPL_MASK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lines_in  (lines_in),
    .reg_valid (reg_valid),
    .reg_write (reg_write),
    .irq_out   (irq_out),
    .event_out (event_out),
    .rise_pend (rise_pend_all),
    .fall_pend (fall_pend_all)
);

// File: tb/tb_edge_irq_ctrl.sv
module tb_edge_irq_ctrl;

    localparam int NB = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB*32-1:0] lines_in = '0;
    logic          reg_valid = 1'b0;
    logic          reg_write = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NB-1:0] irq_out;
    logic [NB*32-1:0] event_out;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #10 clk = ~clk;

    edge_irq_ctrl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .lines_in  (lines_in),
        .reg_valid (reg_valid),
        .reg_write (reg_write),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_out   (irq_out),
        .event_out (event_out)
    );

    // line, mode (1 rise, 2 fall, 3 both), new level, exp rise, exp fall
    localparam logic [11:0] VEC [0:8] = '{
        {7'd3,  2'd1, 1'b1, 1'b1, 1'b0},
        {7'd3,  2'd1, 1'b0, 1'b0, 1'b0},
        {7'd40, 2'd2, 1'b0, 1'b0, 1'b1},
        {7'd40, 2'd2, 1'b1, 1'b0, 1'b0},
        {7'd70, 2'd3, 1'b1, 1'b1, 1'b0},
        {7'd70, 2'd3, 1'b0, 1'b0, 1'b1},
        {7'd31, 2'd3, 1'b1, 1'b1, 1'b0},
        {7'd32, 2'd1, 1'b1, 1'b1, 1'b0},
        {7'd81, 2'd1, 1'b1, 1'b0, 1'b0}
    };

    function automatic logic [7:0] a_rsel(int b); return 8'(b*32 + 0);  endfunction
    function automatic logic [7:0] a_fsel(int b); return 8'(b*32 + 4);  endfunction
    function automatic logic [7:0] a_trg(int b);  return 8'(b*32 + 8);  endfunction
    function automatic logic [7:0] a_rpnd(int b); return 8'(b*32 + 12); endfunction
    function automatic logic [7:0] a_fpnd(int b); return 8'(b*32 + 16); endfunction
    function automatic logic [7:0] a_ien(int b);  return 8'(128 + b*16); endfunction
    function automatic logic [7:0] a_een(int b);  return 8'(132 + b*16); endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        for (int b = 0; b < NB; b++) begin
            rd(a_rsel(b), d); chk(d, 0, "R1 rsel");
            rd(a_fsel(b), d); chk(d, 0, "R1 fsel");
            rd(a_trg(b), d);  chk(d, 0, "R1 trig");
            rd(a_rpnd(b), d); chk(d, 0, "R1 rpend");
            rd(a_fpnd(b), d); chk(d, 0, "R1 fpend");
            rd(a_ien(b), d);  chk(d, 0, "R1 ien");
            rd(a_een(b), d);  chk(d, 0, "R1 een");
        end
        chk(32'(irq_out), 0, "R1 irq");
        chk(event_out[31:0] | event_out[63:32] | event_out[95:64], 0, "R1 event");

        // vector table: R2 R3 R4 R10 R12
        for (int i = 0; i < 9; i++) begin
            int ln, b, bt;
            logic [1:0] md;
            logic dir, er, ef;
            string tag;
            ln = int'(VEC[i][11:5]); md = VEC[i][4:3];
            dir = VEC[i][2]; er = VEC[i][1]; ef = VEC[i][0];
            b = ln / 32; bt = ln % 32;
            tag = (ln >= 81) ? "R10" : (md == 2'd1) ? "R2" : (md == 2'd2) ? "R3" : "R4";
            wr(a_rsel(b), 0); wr(a_fsel(b), 0);
            lines_in[ln] = ~dir;
            repeat (4) @(negedge clk);
            wr(a_rsel(b), md[0] ? (32'd1 << bt) : 32'd0);
            wr(a_fsel(b), md[1] ? (32'd1 << bt) : 32'd0);
            lines_in[ln] = dir;
            repeat (2) @(negedge clk);
            rd(a_rpnd(b), d); chk(d, 0, "R12 not yet");
            rd(a_fpnd(b), d); chk(d, 0, "R12 not yet");
            @(negedge clk);
            rd(a_rpnd(b), d); chk(d, er ? (32'd1 << bt) : 32'd0, tag);
            rd(a_fpnd(b), d); chk(d, ef ? (32'd1 << bt) : 32'd0, tag);
            wr(a_rpnd(b), '1); wr(a_fpnd(b), '1);
            wr(a_rsel(b), 0); wr(a_fsel(b), 0);
            lines_in[ln] = 1'b0;
            repeat (4) @(negedge clk);
        end

        // R11 address map
        wr(a_rsel(1), 32'hA5A5_0001);
        wr(a_fsel(2), 32'h0001_2345);
        wr(a_ien(1), 32'h0000_F00F);
        wr(a_een(2), 32'h0000_0110);
        rd(8'h20, d); chk(d, 32'hA5A5_0001, "R11 rsel b1");
        rd(8'h44, d); chk(d, 32'h0001_2345, "R11 fsel b2");
        rd(8'h90, d); chk(d, 32'h0000_F00F, "R11 ien b1");
        rd(8'hA4, d); chk(d, 32'h0000_0110, "R11 een b2");
        rd(8'h00, d); chk(d, 0, "R11 rsel b0 untouched");
        rd(8'h80, d); chk(d, 0, "R11 ien b0 untouched");
        wr(a_rsel(1), 0); wr(a_fsel(2), 0); wr(a_ien(1), 0); wr(a_een(2), 0);

        // R10 discovery of implemented lines
        wr(a_rsel(2), '1);
        rd(a_rsel(2), d); chk(d, 32'h0001_FFFF, "R10 probe");
        wr(a_rsel(2), 0);

        // R7 software trigger, R8 masked then enabled
        wr(a_trg(0), 32'd1 << 5);
        rd(a_rpnd(0), d); chk(d, 32'd1 << 5, "R7 trig sets rpend");
        rd(a_trg(0), d);  chk(d, 0, "R7 trig reads 0");
        chk(32'(irq_out), 0, "R8 masked");
        wr(a_ien(0), 32'd1 << 5);
        chk(32'(irq_out), 32'b001, "R8 irq bank0");

        // R5 write-one-to-clear
        wr(a_rpnd(0), 0);
        rd(a_rpnd(0), d); chk(d, 32'd1 << 5, "R5 zero keeps");
        chk(32'(irq_out), 32'b001, "R8 level holds");
        wr(a_rpnd(0), 32'd1 << 5);
        rd(a_rpnd(0), d); chk(d, 0, "R5 one clears");
        chk(32'(irq_out), 0, "R8 irq drops");

        // R8 falling flag also raises irq
        wr(a_fsel(1), 32'd1 << 2); wr(a_ien(1), 32'd1 << 2);
        lines_in[34] = 1'b1; repeat (4) @(negedge clk);
        chk(32'(irq_out), 0, "R8 no fall yet");
        lines_in[34] = 1'b0; repeat (3) @(negedge clk);
        chk(32'(irq_out), 32'b010, "R8 irq from fpend");
        wr(a_fpnd(1), '1); wr(a_fsel(1), 0); wr(a_ien(1), 0);
        chk(32'(irq_out), 0, "R8 cleared");

        // R6 collision: edge wins over clear
        wr(a_rsel(0), 32'd1 << 9);
        wr(a_trg(0), 32'd1 << 9);
        lines_in[9] = 1'b1;
        @(negedge clk);
        wr(a_rpnd(0), 32'd1 << 9);
        rd(a_rpnd(0), d); chk(d, 32'd1 << 9, "R6 edge wins");
        wr(a_rpnd(0), 32'd1 << 9);
        rd(a_rpnd(0), d); chk(d, 0, "R6 later clear");
        wr(a_rsel(0), 0);

        // R9 event pulses
        wr(a_rsel(0), (32'd1 << 12) | (32'd1 << 13));
        wr(a_een(0), 32'd1 << 12);
        lines_in[12] = 1'b1; lines_in[13] = 1'b1;
        repeat (3) @(negedge clk);
        chk(32'(event_out[12]), 1, "R9 pulse");
        chk(32'(event_out[13]), 0, "R9 disabled no pulse");
        @(negedge clk);
        chk(32'(event_out[12]), 0, "R9 one cycle");
        rd(a_rpnd(0), d); chk(d, (32'd1 << 12) | (32'd1 << 13), "R9 pend still set");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule